// File: doc/BRIEF.md
# Shared-Adder Arithmetic/Logic Unit

This block is a purely combinational arithmetic/logic unit of parameterised width. Two operands and a 3-bit function code go in; a result word, a zero flag and a signed-overflow flag come out in the same cycle. All arithmetic goes through a single adder. The top bit of the function code does two jobs: it replaces the second operand with its bitwise complement, and it feeds the adder's carry input. Together these turn the adder into a subtractor.

The two low bits of the function code drive a four-way output selector. The choices are a bitwise AND, a bitwise OR, the adder sum, and the sign bit of the sum placed in bit 0 with zeros above it. With the complement bit set, that last choice gives set-if-less-than. It reports the sign of the difference of the operands.

The unit sits in an execution stage. It is used as a drop-in operator with no clock of its own. Codes that are not named below are not rejected. They follow the same selector rule.

Top module: `alu_core`

## Requirements
- R1: Bit 2 of the function code selects the second operand. When it is 0 the true operand is used. When it is 1 its bitwise complement is used. The same bit is the adder carry-in, and this holds for every code.
- R2: Low bits 00 give the bitwise AND of operand A and the selected second operand. Code 000 gives A&B and code 100 gives A&~B.
- R3: Low bits 01 give the bitwise OR of operand A and the selected second operand. Code 001 gives A|B and code 101 gives A|~B.
- R4: Code 010 gives the sum A+B modulo 2^WIDTH.
- R5: Code 110 gives the difference A−B modulo 2^WIDTH, formed as A + ~B + 1.
- R6: Code 111 gives a result whose bit 0 is the most significant bit of A−B (modulo 2^WIDTH) and whose higher bits are all zero.
- R7: Code 011 gives a result whose bit 0 is the most significant bit of A+B and whose higher bits are all zero.
- R8: The zero flag is 1 exactly when every bit of the result is 0, under every code.
- R9: The overflow flag is 1 only under codes 010 and 110, and only when the two's-complement sum or difference does not fit in WIDTH bits. It is 0 under every other code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand, optionally complemented |
| fnCode | input | 3 | Function code: bit 2 complements B and is the carry-in; bits 1:0 choose the output |
| result | output | WIDTH | Selected result word |
| isZero | output | 1 | High when result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest cases to reach are the ones where the adder's sign bit and the true signed order disagree. Set-if-less-than then reports the raw sign of a difference that has overflowed, and the overflow flag must stay low because the code is not add or subtract. Random operands rarely land there. The stimulus therefore pairs the most-negative and most-positive values directly, and runs the same pairs under codes 110, 111 and 011. Zero-flag cases are built on purpose, such as A−A, A+(−A) and AND with a complement, so that an all-zero result appears under several selector paths.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Output selector choice, decoded from function-code bits 1:0
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_SIGN = 2'b11
  } outSel_e;

  // Strobes passed from decode to the datapath
  typedef struct packed {
    logic    invB;
    logic    carryIn;
    outSel_e outSel;
    logic    ovfEn;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] fnCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl.invB    = fnCode[2];
    ctrl.carryIn = fnCode[2];
    ctrl.outSel  = outSel_e'(fnCode[1:0]);
    ctrl.ovfEn   = (fnCode[1:0] == 2'b10);
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             cin,
  output logic [WIDTH-1:0] sum
);

  localparam int PAD = WIDTH - 1;

  assign sum = addA + addB + {{PAD{1'b0}}, cin};

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             isZero,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bSel;
  logic [WIDTH-1:0] sumWord;
  logic [WIDTH-1:0] andWord;
  logic [WIDTH-1:0] orWord;
  logic [WIDTH-1:0] signWord;

  // Per-bit conditional complement of B
  for (genvar i = 0; i < WIDTH; i++) begin : g_binv
    assign bSel[i] = opB[i] ^ ctrl.invB;
  end

  alu_adder #(.WIDTH(WIDTH)) u_adder (
    .addA (opA),
    .addB (bSel),
    .cin  (ctrl.carryIn),
    .sum  (sumWord)
  );

  assign andWord  = opA & bSel;
  assign orWord   = opA | bSel;
  assign signWord = {{MSB{1'b0}}, sumWord[MSB]};

  always_comb begin
    unique case (ctrl.outSel)
      SEL_AND:  result = andWord;
      SEL_OR:   result = orWord;
      SEL_SUM:  result = sumWord;
      SEL_SIGN: result = signWord;
      default:  result = '0;
    endcase
  end

  assign isZero = ~|result;

  // Signed overflow: operands agree in sign, sum disagrees
  assign ovf = ctrl.ovfEn & (opA[MSB] ~^ bSel[MSB]) & (sumWord[MSB] ^ opA[MSB]);

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [2:0]       fnCode,
  output logic [WIDTH-1:0] result,
  output logic             isZero,
  output logic             ovf
);

  aluCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .fnCode (fnCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result),
    .isZero (isZero),
    .ovf    (ovf)
  );

endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [2:0]       fnCode,
  input logic [WIDTH-1:0] result,
  input logic             isZero,
  input logic             ovf
);

  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (fnCode == 3'b000) AST_AND_PLAIN: assert (result == (opA & opB));      // R2
    if (fnCode == 3'b101) AST_OR_INV: assert (result == (opA | ~opB));        // R3
    if (fnCode == 3'b010) AST_ADD_SUM: assert (result == opA + opB);          // R4
    if (fnCode == 3'b110) AST_SUB_DIFF: assert (result == opA - opB);         // R5
    if (fnCode[1:0] == 2'b11) AST_SIGN_ZEXT: assert (result[MSB:1] == '0);    // R6
    if (isZero) AST_ZERO_FLAG: assert (result == '0);                         // R8
    if (fnCode[1:0] != 2'b10) AST_NO_OVERFLOW: assert (!ovf);                 // R9
    if (fnCode == 3'b010 && opA[MSB] != opB[MSB]) AST_ADD_MIXED_SIGN: assert (!ovf); // R9
  end

endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
  .opA    (opA),
  .opB    (opB),
  .fnCode (fnCode),
  .result (result),
  .isZero (isZero),
  .ovf    (ovf)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;

  localparam int W = 32;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MNEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MPOS = {1'b0, {(W-1){1'b1}}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] opA, opB, result;
  logic [2:0]   fnCode;
  logic         isZero, ovf;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  alu_core #(.WIDTH(W)) dut (
    .opA(opA), .opB(opB), .fnCode(fnCode),
    .result(result), .isZero(isZero), .ovf(ovf)
  );

  // Independent model built from the requirements
  function automatic logic [W-1:0] modelRes(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f);
    logic [W-1:0] d;
    logic [W-1:0] s;
    d = a - b;
    s = a + b;
    case (f)
      3'b000: return a & b;
      3'b100: return a & ~b;
      3'b001: return a | b;
      3'b101: return a | ~b;
      3'b010: return s;
      3'b110: return d;
      3'b111: return {{(W-1){1'b0}}, d[W-1]};
      default: return {{(W-1){1'b0}}, s[W-1]};
    endcase
  endfunction

  function automatic logic modelOvf(logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f);
    logic signed [W:0] wide;
    if (f == 3'b010) wide = $signed({a[W-1], a}) + $signed({b[W-1], b});
    else if (f == 3'b110) wide = $signed({a[W-1], a}) - $signed({b[W-1], b});
    else return 1'b0;
    return wide[W] != wide[W-1];
  endfunction

  task automatic checkOne(string tag, logic [W-1:0] a, logic [W-1:0] b, logic [2:0] f);
    logic [W-1:0] expR;
    logic expO;
    @(negedge clk);
    opA = a; opB = b; fnCode = f;
    #2;
    expR = modelRes(a, b, f);
    expO = modelOvf(a, b, f);
    checks++;
    if (result !== expR) begin
      errors++;
      $display("FAIL %s result f=%b a=%h b=%h actual=%h expected=%h", tag, f, a, b, result, expR);
    end
    checks++;
    if (isZero !== (expR == '0)) begin
      errors++;
      $display("FAIL R8 zero (%s) f=%b actual=%b expected=%b", tag, f, isZero, expR == '0);
    end
    checks++;
    if (ovf !== expO) begin
      errors++;
      $display("FAIL R9 ovf (%s) f=%b a=%h b=%h actual=%b expected=%b", tag, f, a, b, ovf, expO);
    end
  endtask

  task automatic testIdle();
    checkOne("R2 idle", ZERO, ZERO, 3'b000);
  endtask

  task automatic testLogic();
    checkOne("R2", 32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);
    checkOne("R1 R2", 32'hF0F0_1234, 32'h0FF0_FFFF, 3'b100);
    checkOne("R3", 32'h1200_0034, 32'h0056_7800, 3'b001);
    checkOne("R1 R3", 32'h1200_0034, 32'h0056_7800, 3'b101);
    checkOne("R1 R2 zero", ONES, ONES, 3'b100);
  endtask

  task automatic testAdd();
    checkOne("R4", 32'd100, 32'd23, 3'b010);
    checkOne("R4 wrap", ONES, 32'd1, 3'b010);
    checkOne("R4 ovf", MPOS, 32'd1, 3'b010);
    checkOne("R4 negovf", MNEG, MNEG, 3'b010);
    checkOne("R4 cancel", 32'd77, -32'd77, 3'b010);
  endtask

  task automatic testSub();
    checkOne("R5", 32'd50, 32'd8, 3'b110);
    checkOne("R5 self", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
    checkOne("R5 ovf", MNEG, 32'd1, 3'b110);
    checkOne("R5 ovf2", MPOS, ONES, 3'b110);
    checkOne("R1 R5 borrow", ZERO, 32'd1, 3'b110);
  endtask

  task automatic testSlt();
    checkOne("R6 lt", 32'd3, 32'd9, 3'b111);
    checkOne("R6 ge", 32'd9, 32'd3, 3'b111);
    checkOne("R6 eq", 32'd9, 32'd9, 3'b111);
    checkOne("R6 neg", ONES, 32'd0, 3'b111);
    checkOne("R6 wrapsign", MNEG, 32'd1, 3'b111);
    checkOne("R6 wrapsign2", MPOS, ONES, 3'b111);
  endtask

  task automatic testSumSign();
    checkOne("R7 neg", ONES, ZERO, 3'b011);
    checkOne("R7 pos", 32'd5, 32'd6, 3'b011);
    checkOne("R7 ovfsign", MPOS, 32'd1, 3'b011);
  endtask

  task automatic testCorners();
    logic [W-1:0] vals [4];
    vals[0] = ZERO; vals[1] = ONES; vals[2] = MNEG; vals[3] = MPOS;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int f = 0; f < 8; f++)
          checkOne("R1 corner", vals[i], vals[j], 3'(f));
  endtask

  task automatic testRandom();
    for (int n = 0; n < 300; n++)
      checkOne("R1 random", $urandom, $urandom, 3'($urandom_range(0, 7)));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    opA = '0; opB = '0; fnCode = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    testIdle();
    testLogic();
    testAdd();
    testSub();
    testSlt();
    testSumSign();
    testCorners();
    testRandom();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule